// File: doc/BRIEF.md
# Processor-Side Memory Bus Master

This block sits between a processor core and a memory that signals the end of each transfer with a completion handshake. The core raises a request with a byte address, a direction, an optional byte-read flag and a burst length. The block then holds the address and data in its own registers and drives one direction line toward memory. It keeps the access open until the memory answers with a completion strobe (MFC). The time a transfer takes is set by the memory, not by a fixed latency.

A burst covers consecutive word locations. Only the first address is presented, and the memory steps through the following words itself. A continuation flag marks every word after the first. Each word ends on its own completion strobe, with one idle gap cycle between words. During a write burst, that gap is also where the core hands over the next word. A byte read fetches the whole word and returns only the lane chosen by the low address bits. If the memory never answers, a watchdog counter ends the transfer with an error.

Controller states: `ST_IDLE` (waiting, accepts requests), `ST_ACCESS` (access open, waiting for MFC), `ST_GAP` (one cycle between burst words), `ST_DONE` (completion pulse), `ST_FAIL` (timeout pulse). Transitions:
- `ST_IDLE` to `ST_ACCESS` on a request.
- `ST_ACCESS` to `ST_DONE` on MFC for the final word.
- `ST_ACCESS` to `ST_GAP` on MFC for any other word.
- `ST_ACCESS` to `ST_FAIL` when the timer expires without MFC.
- `ST_GAP` to `ST_ACCESS` unconditionally.
- `ST_DONE` and `ST_FAIL` to `ST_IDLE` unconditionally.

Top module: `membus_master`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `err_o`, `rvalid_o`, `wnext_o` and `mem_act_o` are all 0.
- R2: A read (`req_we_i`=0) holds `mem_rw_o` at 1 while the access is open. On the final MFC the returned word is presented on `rdata_o`, with `rvalid_o` and `done_o` both high for one cycle.
- R3: A write (`req_we_i`=1) holds `mem_rw_o` at 0 and drives the captured write word on `mem_wdata_o`. `req_byte_i` has no effect on writes: the full word is stored.
- R4: The block never completes a word before MFC is sampled high. With the memory answering in the L-th cycle after the access opens, an N-word transfer raises `done_o` exactly N*(L+1)+N cycles after the accepting edge.
- R5: With `req_byte_i`=1 on a read, `rdata_o` holds the byte in bits [8k+7:8k] of the fetched word, where k = `req_addr_i`[1:0]. The upper 24 bits of `rdata_o` are zero.
- R6: A burst moves `req_len_i`+1 consecutive words. `mem_addr_o` stays at the first byte address for the whole transfer. `mem_seq_o` is 0 for the first word and 1 for every later word. A read burst gives one `rvalid_o` pulse per word, in address order.
- R7: In a write burst, `wnext_o` pulses for one cycle after each non-final word. The word on `req_wdata_i` in that cycle becomes the next word written.
- R8: `busy_o` is 1 from the cycle after acceptance until the cycle of `done_o`. A request made while busy is ignored: it starts no transfer and alters no memory word.
- R9: If MFC has not been seen by the end of the `TIMEOUT_CYC`-th cycle of an open access, `done_o` and `err_o` pulse together and the block returns to idle. MFC arriving exactly in that last cycle still completes normally.
- R10: `done_o` is a single-cycle pulse, and the block accepts a new request in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Core request, sampled in idle |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_byte_i | input | 1 | 1 = single-byte read |
| req_addr_i | input | ADDR_W | Byte address of the first location |
| req_wdata_i | input | DATA_W | Write word (first word at request, later words on `wnext_o`) |
| req_len_i | input | LEN_W | Extra words after the first |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Timeout flag, valid with `done_o` |
| rvalid_o | output | 1 | Read word valid on `rdata_o` |
| wnext_o | output | 1 | Present the next burst write word |
| rdata_o | output | DATA_W | Read word or zero-extended byte |
| mem_addr_o | output | ADDR_W | Address register toward memory |
| mem_rw_o | output | 1 | 1 = read, 0 = write |
| mem_act_o | output | 1 | Access open |
| mem_seq_o | output | 1 | Continuation word of a burst |
| mem_wdata_o | output | DATA_W | Data register toward memory |
| mem_rdata_i | input | DATA_W | Word returned by memory |
| mem_mfc_i | input | 1 | Memory completion strobe |

## Verification
Two situations are hard to reach: a completion strobe landing in the very last cycle before the watchdog fires, and a request that arrives mid-transfer and must be ignored. The bench memory model has a programmable response delay. It sets the delay to exactly one below and one at the timeout limit, so the accept/fail boundary is hit on both sides. For the ignored request, the bench keeps the request line high through a whole transfer while changing the address and direction to a write. It then reads that location back to show it is unchanged. Seeded random transfers mix bursts, byte lanes and delays, and a bench reference memory predicts every returned word.

// File: rtl/membus_pkg.sv
package membus_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ACCESS,
        ST_GAP,
        ST_DONE,
        ST_FAIL
    } bus_state_t;
endpackage

// File: rtl/membus_timer.sv
module membus_timer #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic expired_o
);
    localparam int CNT_W = $clog2(LIMIT + 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!run_i)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    assign expired_o = run_i && (cnt_q == CNT_W'(LIMIT - 1));

    // R9: an open access is never left running past the limit
    a_r9_window_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        run_i |-> (cnt_q < CNT_W'(LIMIT)));
endmodule

// File: rtl/membus_lane.sv
module membus_lane #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0]               word_i,
    input  logic [$clog2(DATA_W/8)-1:0]     off_i,
    input  logic                            byte_i,
    output logic [DATA_W-1:0]               data_o
);
    localparam int LANES = DATA_W / 8;

    logic [7:0] lane_w [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_w[g] = word_i[8*g +: 8];
    end

    always_comb begin
        if (byte_i)
            data_o = {{(DATA_W-8){1'b0}}, lane_w[off_i]};
        else
            data_o = word_i;
    end
endmodule

// File: rtl/membus_ctrl.sv
module membus_ctrl
    import membus_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_i,
    input  logic       mfc_i,
    input  logic       last_i,
    input  logic       expired_i,
    output logic       accept_o,
    output logic       word_ok_o,
    output logic       busy_o,
    output logic       act_o,
    output logic       gap_o,
    output logic       word_end_o,
    output logic       done_o,
    output logic       err_o
);
    bus_state_t state_q, state_n;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_n;
    end

    // transitions
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_i) state_n = ST_ACCESS;
            ST_ACCESS: begin
                if (mfc_i)
                    state_n = last_i ? ST_DONE : ST_GAP;
                else if (expired_i)
                    state_n = ST_FAIL;
            end
            ST_GAP:    state_n = ST_ACCESS;
            ST_DONE:   state_n = ST_IDLE;
            ST_FAIL:   state_n = ST_IDLE;
            default:   state_n = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        accept_o   = (state_q == ST_IDLE) && req_i;
        word_ok_o  = (state_q == ST_ACCESS) && mfc_i;
        busy_o     = (state_q != ST_IDLE);
        act_o      = (state_q == ST_ACCESS);
        gap_o      = (state_q == ST_GAP);
        word_end_o = (state_q == ST_GAP) || (state_q == ST_DONE);
        done_o     = (state_q == ST_DONE) || (state_q == ST_FAIL);
        err_o      = (state_q == ST_FAIL);
    end

    // R4: a successful completion always follows a sampled MFC
    a_r4_done_after_mfc: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DONE) |-> $past(mfc_i));

    // R10: completion is a single-cycle pulse
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R9: a failure only happens when the memory stayed silent
    a_r9_fail_without_mfc: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FAIL) |-> !$past(mfc_i));
endmodule

// File: rtl/membus_master.sv
module membus_master #(
    parameter int ADDR_W      = 32,
    parameter int DATA_W      = 32,
    parameter int LEN_W       = 4,
    parameter int TIMEOUT_CYC = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              req_we_i,
    input  logic              req_byte_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [DATA_W-1:0] req_wdata_i,
    input  logic [LEN_W-1:0]  req_len_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o,
    output logic              rvalid_o,
    output logic              wnext_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              mem_rw_o,
    output logic              mem_act_o,
    output logic              mem_seq_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    input  logic [DATA_W-1:0] mem_rdata_i,
    input  logic              mem_mfc_i
);
    localparam int OFF_W = $clog2(DATA_W / 8);

    logic [ADDR_W-1:0] mar_q;
    logic [DATA_W-1:0] mdr_q;
    logic [LEN_W-1:0]  remain_q;
    logic              rd_q;
    logic              byte_q;
    logic              first_q;

    logic accept, word_ok, gap, word_end, expired, last;

    assign last = (remain_q == '0);

    membus_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_i      (req_i),
        .mfc_i      (mem_mfc_i),
        .last_i     (last),
        .expired_i  (expired),
        .accept_o   (accept),
        .word_ok_o  (word_ok),
        .busy_o     (busy_o),
        .act_o      (mem_act_o),
        .gap_o      (gap),
        .word_end_o (word_end),
        .done_o     (done_o),
        .err_o      (err_o)
    );

    membus_timer #(.LIMIT(TIMEOUT_CYC)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (mem_act_o),
        .expired_o (expired)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mar_q    <= '0;
            mdr_q    <= '0;
            remain_q <= '0;
            rd_q     <= 1'b1;
            byte_q   <= 1'b0;
            first_q  <= 1'b0;
        end else if (accept) begin
            mar_q    <= req_addr_i;
            mdr_q    <= req_wdata_i;
            remain_q <= req_len_i;
            rd_q     <= !req_we_i;
            byte_q   <= req_byte_i && !req_we_i;
            first_q  <= 1'b1;
        end else if (word_ok) begin
            if (rd_q)
                mdr_q <= mem_rdata_i;
            if (!last)
                remain_q <= remain_q - 1'b1;
            first_q <= 1'b0;
        end else if (gap && !rd_q) begin
            mdr_q <= req_wdata_i;
        end
    end

    membus_lane #(.DATA_W(DATA_W)) u_lane (
        .word_i (mdr_q),
        .off_i  (mar_q[OFF_W-1:0]),
        .byte_i (byte_q),
        .data_o (rdata_o)
    );

    assign rvalid_o    = word_end && rd_q;
    assign wnext_o     = gap && !rd_q;
    assign mem_addr_o  = mar_q;
    assign mem_rw_o    = rd_q;
    assign mem_seq_o   = mem_act_o && !first_q;
    assign mem_wdata_o = mdr_q;

    // R6: only the first address is issued; it holds through the burst
    a_r6_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> $stable(mem_addr_o));

    // R2: the direction line does not change inside a transfer
    a_r2_dir_held: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> $stable(mem_rw_o));

    // R8: nothing new is captured while busy
    a_r8_no_capture_busy: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(busy_o) && busy_o && !$past(word_ok)) |-> $stable(remain_q));
endmodule

// File: tb/test_membus_master.sv
`timescale 1ns/1ps
module test_membus_master;
    localparam int AW = 32;
    localparam int DW = 32;
    localparam int LW = 4;
    localparam int TO = 16;
    localparam int MW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_i = 1'b0;
    logic          req_we_i = 1'b0;
    logic          req_byte_i = 1'b0;
    logic [AW-1:0] req_addr_i = '0;
    logic [DW-1:0] req_wdata_i = '0;
    logic [LW-1:0] req_len_i = '0;
    logic          busy_o, done_o, err_o, rvalid_o, wnext_o;
    logic [DW-1:0] rdata_o;
    logic [AW-1:0] mem_addr_o;
    logic          mem_rw_o, mem_act_o, mem_seq_o;
    logic [DW-1:0] mem_wdata_o;
    logic [DW-1:0] mem_rdata_i = '0;
    logic          mem_mfc_i = 1'b0;

    int checks = 0;
    int errors = 0;
    int lat = 0;

    logic [DW-1:0] model_mem [MW];
    logic [DW-1:0] ref_mem   [MW];
    logic [3:0]    mdl_ptr = '0;
    logic [3:0]    mdl_idx;
    int            mdl_cnt = 0;

    always #2.5 clk = ~clk;

    membus_master #(.ADDR_W(AW), .DATA_W(DW), .LEN_W(LW), .TIMEOUT_CYC(TO)) i_membus_master (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .req_we_i(req_we_i),
        .req_byte_i(req_byte_i), .req_addr_i(req_addr_i), .req_wdata_i(req_wdata_i),
        .req_len_i(req_len_i), .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
        .rvalid_o(rvalid_o), .wnext_o(wnext_o), .rdata_o(rdata_o),
        .mem_addr_o(mem_addr_o), .mem_rw_o(mem_rw_o), .mem_act_o(mem_act_o),
        .mem_seq_o(mem_seq_o), .mem_wdata_o(mem_wdata_o),
        .mem_rdata_i(mem_rdata_i), .mem_mfc_i(mem_mfc_i)
    );

    // memory model: answers `lat` negedges after the access opens
    always @(negedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < MW; i++) model_mem[i] <= 32'h1000_0000 + 32'h0101_0101 * i;
            mem_mfc_i <= 1'b0;
            mdl_cnt   <= 0;
        end else if (mem_mfc_i) begin
            mem_mfc_i <= 1'b0;
            mdl_cnt   <= 0;
        end else if (mem_act_o) begin
            if (mdl_cnt == lat) begin
                mdl_idx = mem_seq_o ? mdl_ptr : mem_addr_o[5:2];
                if (mem_rw_o) mem_rdata_i <= model_mem[mdl_idx];
                else          model_mem[mdl_idx] <= mem_wdata_o;
                mdl_ptr   <= mdl_idx + 4'd1;
                mem_mfc_i <= 1'b1;
            end else begin
                mdl_cnt <= mdl_cnt + 1;
            end
        end else begin
            mdl_cnt <= 0;
        end
    end

    function automatic logic [DW-1:0] pick(input logic [DW-1:0] w, input bit b, input logic [1:0] off);
        if (b) return (w >> (8 * off)) & 32'hFF;
        return w;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic run_txn(input bit we, input bit bsel, input logic [AW-1:0] addr,
                           input int len, input int l, input bit hold);
        logic [DW-1:0] wd [4];
        int words, cycles, ridx, widx, guard;
        bit fin;
        logic [3:0] base;
        words = len + 1;
        base  = addr[5:2];
        for (int k = 0; k < 4; k++) wd[k] = $urandom;
        lat = l;
        @(negedge clk);
        req_i = 1'b1; req_we_i = we; req_byte_i = bsel; req_addr_i = addr;
        req_len_i = LW'(len); req_wdata_i = wd[0];
        @(posedge clk);
        @(negedge clk);
        if (hold) begin
            req_addr_i = 32'd60; req_we_i = 1'b1; req_wdata_i = 32'hDEAD_BEEF;
        end else begin
            req_i = 1'b0;
        end
        cycles = 1; ridx = 0; widx = 0; guard = 0; fin = 0;
        while (!fin && guard < 2000) begin
            if (mem_act_o) begin
                chk(mem_rw_o == !we, we ? "R3 dir" : "R2 dir", {31'd0, mem_rw_o}, {31'd0, !we});
                chk(mem_addr_o == addr, "R6 addr held", mem_addr_o, addr);
                chk(mem_seq_o == (ridx + widx != 0), "R6 seq flag", {31'd0, mem_seq_o}, 32'(ridx + widx != 0));
                if (we) chk(mem_wdata_o == wd[widx], "R7 write word", mem_wdata_o, wd[widx]);
            end
            if (rvalid_o) begin
                chk(rdata_o == pick(ref_mem[4'(base + ridx)], bsel, addr[1:0]),
                    bsel ? "R5 byte lane" : "R2 read word", rdata_o,
                    pick(ref_mem[4'(base + ridx)], bsel, addr[1:0]));
                ridx++;
            end
            if (wnext_o) begin
                widx++;
                req_wdata_i = wd[widx];
            end
            if (done_o) begin
                fin = 1;
                if (hold) req_i = 1'b0;
            end else begin
                chk(busy_o == 1'b1, "R8 busy", {31'd0, busy_o}, 32'd1);
                @(negedge clk);
                cycles++;
                guard++;
            end
        end
        chk(err_o == 1'b0, "R9 no error", {31'd0, err_o}, 32'd0);
        chk(cycles == words * (l + 2), "R4 completion time", 32'(cycles), 32'(words * (l + 2)));
        if (!we) chk(ridx == words, "R6 word count", 32'(ridx), 32'(words));
        else     chk(widx == words - 1, "R7 wnext count", 32'(widx), 32'(words - 1));
        if (we) for (int k = 0; k < words; k++) ref_mem[4'(base + k)] = wd[k];
        @(negedge clk);
        chk(done_o == 1'b0 && busy_o == 1'b0, "R10 back to idle", {30'd0, done_o, busy_o}, 32'd0);
    endtask

    task automatic run_timeout(input int l, input bit expect_err);
        int cycles;
        lat = l;
        @(negedge clk);
        req_i = 1'b1; req_we_i = 1'b0; req_byte_i = 1'b0; req_addr_i = 32'd8; req_len_i = '0;
        @(posedge clk);
        @(negedge clk);
        req_i = 1'b0;
        cycles = 1;
        while (!done_o && cycles < 2000) begin
            @(negedge clk);
            cycles++;
        end
        chk(err_o == expect_err, "R9 error flag", {31'd0, err_o}, {31'd0, expect_err});
        chk(cycles == (expect_err ? TO + 1 : l + 2), "R9 timeout cycle", 32'(cycles),
            32'(expect_err ? TO + 1 : l + 2));
        if (!expect_err) chk(rdata_o == ref_mem[2], "R9 late mfc data", rdata_o, ref_mem[2]);
        @(negedge clk);
        chk(busy_o == 1'b0 && mem_act_o == 1'b0, "R9 idle after", {30'd0, busy_o, mem_act_o}, 32'd0);
    endtask

    initial begin
        #1ms;
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < MW; i++) ref_mem[i] = 32'h1000_0000 + 32'h0101_0101 * i;
        repeat (4) @(negedge clk);
        // R1 reset state
        chk({busy_o, done_o, err_o, rvalid_o, wnext_o, mem_act_o} == 6'd0, "R1 reset outputs",
            {26'd0, busy_o, done_o, err_o, rvalid_o, wnext_o, mem_act_o}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({busy_o, done_o, mem_act_o} == 3'd0, "R1 idle after reset",
            {29'd0, busy_o, done_o, mem_act_o}, 32'd0);

        run_txn(0, 0, 32'd4, 0, 0, 0);         // R2 single read, fast memory
        run_txn(0, 0, 32'd12, 0, 3, 0);        // R4 slow memory
        run_txn(1, 1, 32'd20, 0, 1, 0);        // R3 write with byte flag ignored
        run_txn(0, 0, 32'd20, 0, 0, 0);        // R3 full word stored
        for (int k = 0; k < 4; k++)
            run_txn(0, 1, 32'd20 + k, 0, 1, 0); // R5 every byte lane
        run_txn(0, 0, 32'd56, 3, 2, 0);        // R6 read burst with wrap
        run_txn(1, 0, 32'd32, 3, 1, 0);        // R7 write burst
        run_txn(0, 0, 32'd32, 3, 0, 0);        // R7 burst read back
        run_txn(0, 0, 32'd16, 1, 2, 1);        // R8 request held while busy
        run_txn(0, 0, 32'd60, 0, 0, 0);        // R8 location 60 unchanged
        run_timeout(TO - 1, 0);                // R9 mfc in last allowed cycle
        run_timeout(TO, 1);                    // R9 one cycle too late
        run_timeout(1000, 1);                  // R9 memory silent
        run_txn(0, 0, 32'd0, 0, 0, 0);         // R10 recovers after timeout

        for (int n = 0; n < 40; n++) begin
            automatic bit we   = 1'($urandom % 2);
            automatic bit bsel = 1'($urandom % 2);
            run_txn(we, bsel, 32'($urandom % 64), int'($urandom % 4), int'($urandom % 5), 0);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule